// File: doc/BRIEF.md
# Watch Timer with Buzzer

This block turns a 32.768 kHz time base into the periodic signals that a small clock-keeping system needs. These signals are a watch interrupt for real-time keeping or interval measurement, a square-wave buzzer tone at one of four pitches, and a slow clock for an LCD controller. All three are drawn from a single binary counter that advances once per time-base tick.

The time base has two possible sources. The first is the 4.19 MHz main clock divided by a parameterised prescaler, which defaults to 128. The second is a sub-system oscillator signal, which the block samples in the main clock domain. The block synchronises it and turns each rising edge into a one-cycle tick. While the block is disabled, the prescaler, the counter and the interrupt are all held at zero and the buzzer pin stays low. After enable, everything restarts from a known phase.

Top module: `watch_buzzer_timer`

## Requirements
- R1: With `src_sub`=0, one time-base tick occurs every MAIN_DIV clock cycles while enabled. The counter advances by one on the cycle after each tick.
- R2: With `src_sub`=1, each rising edge of `sub_clk_in` produces one time-base tick. The tick comes SYNC_STAGES+1 clock edges after the first edge that samples the new level.
- R3: `buz_sel` codes 0, 1, 2 and 3 select buzzer periods of 16, 8, 4 and 2 time-base ticks, which is 2, 4, 8 and 16 kHz from a 32.768 kHz base. The output equals counter bit BUZ_LO+3-code, and a new code takes effect immediately.
- R4: The buzzer output has a 50% duty cycle. It is high for exactly half of each selected period.
- R5: With `fast_irq`=0, `watch_irq` is a single-cycle pulse. It fires one cycle after every tick that carries the low SLOW_BITS counter bits from all ones to zero. By default this is every 2^14 ticks, or 0.5 s.
- R6: With `fast_irq`=1, the interrupt uses the low FAST_BITS counter bits instead. By default this is every 2^7 ticks, or about 3.9 ms. The selection is sampled on each tick.
- R7: `lcd_clk` equals counter bit LCD_BIT, so its period is 2^(LCD_BIT+1) ticks.
- R8: While `enable`=0, `buzzer` is low and the counter, prescaler and interrupt are cleared on each clock. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider chain; 0 holds it cleared |
| src_sub | input | 1 | Time-base source: 0 main clock prescaled, 1 sub oscillator |
| sub_clk_in | input | 1 | Sub-system oscillator level, asynchronous to clk |
| buz_sel | input | 2 | Buzzer pitch code 0..3 (2, 4, 8, 16 kHz) |
| fast_irq | input | 1 | 1 selects the short interrupt interval |
| buzzer | output | 1 | Square-wave buzzer pin |
| watch_irq | output | 1 | One-cycle watch interrupt pulse |
| lcd_clk | output | 1 | Clock for the LCD controller |

## Verification
The interrupt pulse, a buzzer edge and an LCD clock edge all come from the same counter rollover, so they land in the same cycle whenever the low counter bits wrap together. The bench reaches this in both source modes and in both interval modes. It also switches `fast_irq` and `buz_sel` during a run, so that a mode change can fall on the cycle of a rollover. An arithmetic model of the tick times and the counter value predicts every output on every cycle, and each of the three outputs is compared separately in every cycle.

// File: rtl/wt_pkg.sv
package wt_pkg;

   typedef enum logic {
      WT_SRC_MAIN = 1'b0,
      WT_SRC_SUB  = 1'b1
   } wt_src_e;

   // counter bit that carries a buzzer code: code 3 is the fastest pitch
   function automatic int unsigned wt_buz_tap(input int unsigned lo, input int unsigned code);
      return lo + 3 - code;
   endfunction

endpackage

// File: rtl/wt_timebase.sv
module wt_timebase
   import wt_pkg::*;
#(
   parameter int unsigned MAIN_DIV    = 128,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    en,
   input  wt_src_e src,
   input  logic    sub_clk_in,
   output logic    base_tick
);

   localparam int unsigned PW       = (MAIN_DIV > 2) ? $clog2(MAIN_DIV) : 1;
   localparam bit          DIV_POW2 = ((MAIN_DIV & (MAIN_DIV - 1)) == 0);

   initial begin
      assert (MAIN_DIV >= 2) else $fatal(1, "MAIN_DIV must be at least 2");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   // ---------------- main-clock prescaler ----------------
   logic [PW-1:0] pre_q;
   logic          main_tick;
   logic          pre_run;

   assign pre_run = en && (src == WT_SRC_MAIN);

   generate
      if (DIV_POW2) begin : g_pow2
         // power-of-two ratio: free wrap, tick on all ones
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (!en)     pre_q <= '0;
            else if (pre_run) pre_q <= pre_q + 1'b1;
         end
         assign main_tick = &pre_q;
      end else begin : g_modn
         // arbitrary ratio: compare and clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (!en)     pre_q <= '0;
            else if (pre_run) pre_q <= (pre_q == PW'(MAIN_DIV - 1)) ? '0 : pre_q + 1'b1;
         end
         assign main_tick = (pre_q == PW'(MAIN_DIV - 1));
      end
   endgenerate

   // ---------------- sub-oscillator sampler ----------------
   // stages 0..SYNC_STAGES-1 resynchronise, the last one holds the previous level
   logic [SYNC_STAGES:0] sync_q;
   logic                 sub_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], sub_clk_in};
   end

   assign sub_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   // ---------------- registered tick ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_tick <= 1'b0;
      else        base_tick <= en && ((src == WT_SRC_MAIN) ? main_tick : sub_rise);
   end

   // a tick never lasts more than one cycle, in either source mode
   assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      base_tick |=> !base_tick);

endmodule

// File: rtl/wt_divchain.sv
module wt_divchain #(
   parameter int unsigned CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   initial begin
      assert (CNT_W >= 4) else $fatal(1, "CNT_W must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!en)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   assert_clear_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   assert_step_per_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick) |=> (!$past(en) || (cnt == CNT_W'($past(cnt) + 1'b1))));

endmodule

// File: rtl/wt_taps.sv
module wt_taps
   import wt_pkg::*;
#(
   parameter int unsigned CNT_W     = 15,
   parameter int unsigned SLOW_BITS = 14,
   parameter int unsigned FAST_BITS = 7,
   parameter int unsigned LCD_BIT   = 8,
   parameter int unsigned BUZ_LO    = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [1:0]       buz_sel,
   input  logic             fast,
   output logic             buzzer,
   output logic             irq,
   output logic             lcd_clk
);

   localparam logic [CNT_W-1:0] SLOW_MASK = {CNT_W{1'b1}} >> (CNT_W - SLOW_BITS);
   localparam logic [CNT_W-1:0] FAST_MASK = {CNT_W{1'b1}} >> (CNT_W - FAST_BITS);

   initial begin
      assert (SLOW_BITS <= CNT_W && SLOW_BITS >= 1) else $fatal(1, "SLOW_BITS out of range");
      assert (FAST_BITS >= 1 && FAST_BITS < SLOW_BITS) else $fatal(1, "FAST_BITS out of range");
      assert (LCD_BIT < CNT_W) else $fatal(1, "LCD_BIT out of range");
      assert (BUZ_LO + 3 < CNT_W) else $fatal(1, "BUZ_LO out of range");
   end

   // ---------------- buzzer tap mux ----------------
   logic [3:0] tap_w;

   generate
      for (genvar g = 0; g < 4; g++) begin : g_tap
         assign tap_w[g] = cnt[wt_buz_tap(BUZ_LO, g)];
      end
   endgenerate

   assign buzzer  = en & tap_w[buz_sel];
   assign lcd_clk = cnt[LCD_BIT];

   // ---------------- interval interrupt ----------------
   logic [CNT_W-1:0] win_mask;
   logic             wrap_hit;

   assign win_mask = fast ? FAST_MASK : SLOW_MASK;
   assign wrap_hit = ((cnt & win_mask) == win_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= en && tick && wrap_hit;
   end

   assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // the pulse coincides with the counter having just rolled its low bits to zero
   assert_irq_on_rollover_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((cnt & FAST_MASK) == '0));

   assert_lcd_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && $past(!en)) |-> !lcd_clk);

endmodule

// File: rtl/watch_buzzer_timer.sv
module watch_buzzer_timer
   import wt_pkg::*;
#(
   parameter int unsigned MAIN_DIV    = 128,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CNT_W       = 15,
   parameter int unsigned SLOW_BITS   = 14,
   parameter int unsigned FAST_BITS   = 7,
   parameter int unsigned LCD_BIT     = 8,
   parameter int unsigned BUZ_LO      = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       src_sub,
   input  logic       sub_clk_in,
   input  logic [1:0] buz_sel,
   input  logic       fast_irq,
   output logic       buzzer,
   output logic       watch_irq,
   output logic       lcd_clk
);

   wt_src_e          src;
   logic             tick;
   logic [CNT_W-1:0] cnt;

   assign src = src_sub ? WT_SRC_SUB : WT_SRC_MAIN;

   wt_timebase #(
      .MAIN_DIV    (MAIN_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (enable),
      .src        (src),
      .sub_clk_in (sub_clk_in),
      .base_tick  (tick)
   );

   wt_divchain #(
      .CNT_W (CNT_W)
   ) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .tick  (tick),
      .cnt   (cnt)
   );

   wt_taps #(
      .CNT_W     (CNT_W),
      .SLOW_BITS (SLOW_BITS),
      .FAST_BITS (FAST_BITS),
      .LCD_BIT   (LCD_BIT),
      .BUZ_LO    (BUZ_LO)
   ) u_taps (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (enable),
      .tick    (tick),
      .cnt     (cnt),
      .buz_sel (buz_sel),
      .fast    (fast_irq),
      .buzzer  (buzzer),
      .irq     (watch_irq),
      .lcd_clk (lcd_clk)
   );

endmodule

// File: tb/sim_watch_buzzer_timer.sv
module sim_watch_buzzer_timer;

   localparam int DIV   = 4;
   localparam int SYNC  = 2;
   localparam int CW    = 9;
   localparam int SLOWB = 6;
   localparam int FASTB = 3;
   localparam int LCDB  = 5;
   localparam int BLO   = 0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic       src_sub = 1'b0;
   logic       sub_clk_in = 1'b0;
   logic [1:0] buz_sel = 2'd0;
   logic       fast_irq = 1'b0;
   logic       buzzer, watch_irq, lcd_clk;

   always #5 clk = ~clk;

   watch_buzzer_timer #(
      .MAIN_DIV (DIV), .SYNC_STAGES (SYNC), .CNT_W (CW),
      .SLOW_BITS (SLOWB), .FAST_BITS (FASTB), .LCD_BIT (LCDB), .BUZ_LO (BLO)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .enable (enable), .src_sub (src_sub),
      .sub_clk_in (sub_clk_in), .buz_sel (buz_sel), .fast_irq (fast_irq),
      .buzzer (buzzer), .watch_irq (watch_irq), .lcd_clk (lcd_clk)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // arithmetic model state, valid after each active edge
   int pre_m = 0, cnt_m = 0;
   bit tick_m = 0, irq_m = 0;
   bit rise_h [1:SYNC+1];
   string phase = "reset";

   // next input values, applied just after the edge
   bit         n_en = 0, n_src = 0, n_sub = 0, n_fast = 0;
   logic [1:0] n_sel = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, phase, $time, act, exp);
      end
   endtask

   task automatic step();
      int  mask;
      bit  new_tick, new_irq;
      int  new_cnt;
      @(posedge clk);
      // model the edge with the inputs the design just sampled
      mask     = fast_irq ? ((1 << FASTB) - 1) : ((1 << SLOWB) - 1);
      new_irq  = enable && tick_m && ((cnt_m & mask) == mask);
      new_cnt  = enable ? ((cnt_m + int'(tick_m)) % (1 << CW)) : 0;
      new_tick = enable && (src_sub ? rise_h[SYNC+1] : (pre_m == DIV - 1));
      pre_m    = !enable ? 0 : (!src_sub ? (pre_m + 1) % DIV : pre_m);
      tick_m   = new_tick;
      cnt_m    = new_cnt;
      irq_m    = new_irq;
      for (int j = SYNC + 1; j > 1; j--) rise_h[j] = rise_h[j-1];
      #1;
      rise_h[1]  = n_sub && !sub_clk_in;
      enable     = n_en;
      src_sub    = n_src;
      sub_clk_in = n_sub;
      fast_irq   = n_fast;
      buz_sel    = n_sel;
      @(negedge clk);
      begin
         int b_exp, l_exp;
         b_exp = int'(enable) & ((cnt_m >> (BLO + 3 - int'(buz_sel))) & 1);
         l_exp = (cnt_m >> LCDB) & 1;
         check(buzzer == b_exp[0], enable ? "R3/R4" : "R8", int'(buzzer), b_exp);
         check(watch_irq == irq_m, fast_irq ? "R6" : "R5", int'(watch_irq), int'(irq_m));
         check(lcd_clk == l_exp[0], "R7", int'(lcd_clk), l_exp);
      end
   endtask

   int irq_seen;

   initial begin
      for (int j = 1; j <= SYNC + 1; j++) rise_h[j] = 0;
      #2;
      // reset state R8
      check(buzzer == 0 && watch_irq == 0 && lcd_clk == 0, "R8",
            int'({buzzer, watch_irq, lcd_clk}), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // main source, slow interval, sweep all buzzer codes (R1 R3 R4 R5 R7)
      phase = "R1 main slow";
      n_en = 1; n_src = 0; n_fast = 0;
      irq_seen = 0;
      for (int c = 0; c < 4; c++) begin
         n_sel = 2'(c);
         for (int i = 0; i < 330; i++) begin
            step();
            irq_seen += int'(watch_irq);
         end
      end
      // 1320 cycles at 256 cycles per interval: five pulses R5
      check(irq_seen == 5, "R5", irq_seen, 5);

      // fast interval on the main source, buzzer code changes mid-run (R6)
      phase = "R6 main fast";
      n_fast = 1;
      irq_seen = 0;
      for (int i = 0; i < 640; i++) begin
         n_sel = 2'((i / 37) % 4);
         step();
         irq_seen += int'(watch_irq);
      end
      // 32 cycles per interval; the first pulse may belong to the slow window
      check(irq_seen >= 19 && irq_seen <= 21, "R6", irq_seen, 20);

      // disable mid-run, then restart (R8)
      phase = "R8 disable";
      n_en = 0;
      for (int i = 0; i < 20; i++) step();
      check(buzzer == 0 && lcd_clk == 0 && watch_irq == 0, "R8",
            int'({buzzer, watch_irq, lcd_clk}), 0);
      n_en = 1; n_fast = 0; n_sel = 2'd3;
      for (int i = 0; i < 300; i++) step();

      // switch to the sub oscillator while stopped (R2)
      phase = "R2 sub";
      n_en = 0;
      for (int i = 0; i < 8; i++) step();
      n_src = 1;
      step();
      n_en = 1;
      irq_seen = 0;
      for (int i = 0; i < 2400; i++) begin
         n_sub = ((i / 3) % 2) == 1;
         if (i == 1500) n_fast = 1;
         n_sel = 2'((i / 200) % 4);
         step();
         irq_seen += int'(watch_irq);
      end
      // 384 cycles per slow interval before 1500, 48 per fast interval after
      check(irq_seen >= 20 && irq_seen <= 23, "R2", irq_seen, 21);

      // sub source with the clock held still: no tick, outputs frozen (R2)
      phase = "R2 sub idle";
      n_sub = 0;
      for (int i = 0; i < 10; i++) step();
      begin
         logic b0, l0;
         b0 = buzzer; l0 = lcd_clk;
         for (int i = 0; i < 40; i++) step();
         check(buzzer == b0 && lcd_clk == l0, "R2", int'({buzzer, lcd_clk}), int'({b0, l0}));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog (%s) actual=running expected=finished", phase);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule